// File: doc/BRIEF.md
# Interprocessor and Interval-Timer Interrupt Unit

This unit serves a four-processor system. It keeps one 64-bit control/status word that holds each processor's interprocessor-interrupt flag and interval-timer-interrupt flag, plus a few arbitration-related fields. Each field has its own write rule. Writing a one can clear a bit, set a bit, set a bit only while its field is empty, or set a bit in a different field. The word drives one interprocessor-interrupt line and one timer-interrupt line per processor.

Each processor also has an ignore counter. A periodic tick input decrements all counters. The tick is taken on its rising edge only, so a level held high for many clocks counts once. When a counter decrements past zero it raises a sticky overflow flag. From then on, every tick re-asserts that processor's timer-interrupt flag until software rewrites the counter.

Software reaches the unit through a one-cycle read strobe and a one-cycle write strobe. Each access carries a register select, a 64-bit write value and the index of the requesting processor. There is no back-pressure. Read data returns exactly one cycle after the read strobe, qualified by `rd_valid`. A read returns the state as it was before any write in the same cycle.

Top module: `cpu_event_irq_unit`

## Requirements
- R1: After reset, the control word, every counter, `rd_valid`, `ipi_irq` and `tmr_irq` are all zero.
- R2: When `reg_rd` is high, `rd_valid` is high on the next cycle together with `rd_data`. Select 0 returns the control word with `reg_cpu` ORed into bits 1:0. Select 4+i returns counter i, zero-extended from 25 bits with the overflow flag in bit 24.
- R3: On a write to select 0, every 1 in write bits 11:4 or bit 28 clears that stored bit. Bit 28 has no set path and always reads as 0.
- R4: On a write to select 0 with write bit 20 set, stored bits 23:16 become 0. Otherwise write bits 23:20 are ORed into storage, and write bits 19:16 are ORed in only while stored bits 19:16 are all zero.
- R5: On a write to select 0, write bit 12+i sets stored bit 8+i. If the same write also clears that bit, the set wins.
- R6: On a write to select 0, stored bits 43:40 take write bits 43:40.
- R7: `ipi_irq[i]` equals stored bit 8+i and `tmr_irq[i]` equals stored bit 4+i.
- R8: A write to select 4+i stores write bits 23:0 into counter i and clears its overflow flag, bit 24. Upper write bits are dropped.
- R9: On each rising edge of `tick_in`, every counter's 25-bit value is decremented modulo 2^25, and bit 24 is then ORed with its old value. A level held high gives exactly one decrement, and a falling edge does nothing. A counter written in the same cycle takes the written value instead.
- R10: On the same clock edge as a tick's decrement, the unit sets stored bit 4+i for every counter i whose overflow flag is set after the tick. This set wins over a clear in the same cycle.
- R11: Selects 1, 2 and 3 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_in | input | 1 | Interval-timer tick level; acted on at its rising edge |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_sel | input | 3 | Register select: 0 control word, 4+i counter i |
| reg_cpu | input | 2 | Index of the requesting processor |
| reg_wdata | input | 64 | Write value |
| rd_valid | output | 1 | Read data valid, one cycle after `reg_rd` |
| rd_data | output | 64 | Read data |
| ipi_irq | output | 4 | Interprocessor-interrupt line per processor |
| tmr_irq | output | 4 | Interval-timer-interrupt line per processor |

## Verification
The bench builds the unit with its defaults: four processors and 24-bit counters. Counters leave reset at zero, so the first tick already wraps three of them to 0x1FFFFFF with the overflow flag set. This makes the wrap path and the sticky re-assertion of the timer flag reachable within a handful of ticks, next to a counter loaded with 2 that counts down to its own wrap. Walking the full 24-bit range is out of reach and is not attempted.

// File: rtl/cpu_evt_pkg.sv
package cpu_evt_pkg;
  localparam int DATA_W    = 64;
  localparam int SEL_W     = 3;
  localparam int MAX_CPU   = 4;
  // control word field positions (decoded by the interrupt lines)
  localparam int TMR_LSB   = 4;
  localparam int IPI_LSB   = 8;
  localparam int REQ_LSB   = 12;
  localparam int ONCE_LSB  = 16;
  localparam int ONCE_W    = 4;
  localparam int ACC_LSB   = 20;
  localparam int ACC_W     = 4;
  localparam int WIPE_BIT  = 20;
  localparam int CLR28_BIT = 28;
  localparam int RW_LSB    = 40;
  localparam int RW_W      = 4;
  localparam logic [DATA_W-1:0] W1C_MASK = 64'h0000_0000_1000_0FF0;
  localparam logic [DATA_W-1:0] KEEP_MASK = 64'h0000_0F00_00FF_0FF0;
  localparam logic [SEL_W-1:0] SEL_CTRL = 3'd0;
endpackage

// File: rtl/tick_edge.sv
module tick_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_rise
);
  logic tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= 1'b0;
    else        tick_q <= tick_in;
  end

  assign tick_rise = tick_in & ~tick_q;

  // R9: a held level never yields two decrements in a row
  assert_one_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick_rise |=> !tick_rise);
endmodule

// File: rtl/ignore_counter.sv
module ignore_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic             tick,
  output logic [CNT_W:0]   cnt_q,
  output logic             set_tmr
);
  localparam int FULL_W = CNT_W + 1;
  logic [CNT_W:0] dec;

  always_comb begin
    dec = cnt_q - {{CNT_W{1'b0}}, 1'b1};
    dec[CNT_W] = dec[CNT_W] | cnt_q[CNT_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_q <= '0;
    else if (wr)    cnt_q <= {1'b0, wdata};
    else if (tick)  cnt_q <= dec;
  end

  assign set_tmr = tick & ~wr & dec[CNT_W];

  // R8: a write loads the low field and drops the overflow flag
  assert_load_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (cnt_q == {1'b0, $past(wdata)}));
  // R9: overflow is sticky across ticks
  assert_sticky_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !wr && cnt_q[CNT_W]) |=> cnt_q[CNT_W]);
  // R9: without tick or write the counter holds
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr) |=> $stable(cnt_q));

  initial begin
    assert_width_ok: assert (FULL_W > 1);
  end
endmodule

// File: rtl/ctrl_word.sv
module ctrl_word
  import cpu_evt_pkg::*;
#(
  parameter int NCPU = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NCPU-1:0]   set_tmr,
  output logic [DATA_W-1:0] word_q
);
  logic [DATA_W-1:0] nxt;

  always_comb begin
    nxt = word_q;
    if (wr) begin
      nxt = nxt & ~(wdata & W1C_MASK);
      if (wdata[WIPE_BIT]) begin
        nxt[ONCE_LSB +: ONCE_W + ACC_W] = '0;
      end else begin
        nxt[ACC_LSB +: ACC_W] = nxt[ACC_LSB +: ACC_W] | wdata[ACC_LSB +: ACC_W];
        if (nxt[ONCE_LSB +: ONCE_W] == '0)
          nxt[ONCE_LSB +: ONCE_W] = wdata[ONCE_LSB +: ONCE_W];
      end
      nxt[IPI_LSB +: NCPU] = nxt[IPI_LSB +: NCPU] | wdata[REQ_LSB +: NCPU];
      nxt[RW_LSB +: RW_W] = wdata[RW_LSB +: RW_W];
    end
    nxt[TMR_LSB +: NCPU] = nxt[TMR_LSB +: NCPU] | set_tmr;
    nxt = nxt & KEEP_MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= nxt;
  end

  // R4: the wipe bit empties both arbitration fields
  assert_wipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && wdata[WIPE_BIT]) |=> (word_q[ONCE_LSB +: ONCE_W + ACC_W] == '0));
  // R5: request bits always land in the interprocessor field
  assert_req_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> ((word_q[IPI_LSB +: NCPU] & $past(wdata[REQ_LSB +: NCPU]))
            == $past(wdata[REQ_LSB +: NCPU])));
  // R6: plain field follows the written value
  assert_plain_field_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (word_q[RW_LSB +: RW_W] == $past(wdata[RW_LSB +: RW_W])));
  // R10: a tick with overflow raises the timer flag
  assert_tmr_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (set_tmr != '0) |=> ((word_q[TMR_LSB +: NCPU] & $past(set_tmr)) == $past(set_tmr)));
  // R3: bit 28 never reads back as set
  assert_bit28_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !word_q[CLR28_BIT]);
endmodule

// File: rtl/cpu_event_irq_unit.sv
module cpu_event_irq_unit
  import cpu_evt_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_in,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [1:0]        reg_cpu,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [NCPU-1:0]   ipi_irq,
  output logic [NCPU-1:0]   tmr_irq
);
  localparam int PAD_W = DATA_W - CNT_W - 1;

  logic              tick_rise;
  logic              wr_ctrl;
  logic [NCPU-1:0]   wr_cnt;
  logic [NCPU-1:0]   set_tmr;
  logic [CNT_W:0]    cnt [NCPU];
  logic [DATA_W-1:0] word_q;
  logic [DATA_W-1:0] rd_mux;

  tick_edge u_edge (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_rise(tick_rise)
  );

  assign wr_ctrl = reg_wr && (reg_sel == SEL_CTRL);

  for (genvar i = 0; i < NCPU; i++) begin : g_cnt
    assign wr_cnt[i] = reg_wr && reg_sel[SEL_W-1] && (reg_sel[SEL_W-2:0] == i[SEL_W-2:0]);
    ignore_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .wr(wr_cnt[i]), .wdata(reg_wdata[CNT_W-1:0]),
      .tick(tick_rise), .cnt_q(cnt[i]), .set_tmr(set_tmr[i])
    );
  end

  ctrl_word #(.NCPU(NCPU)) u_word (
    .clk(clk), .rst_n(rst_n), .wr(wr_ctrl), .wdata(reg_wdata),
    .set_tmr(set_tmr), .word_q(word_q)
  );

  always_comb begin
    rd_mux = '0;
    if (reg_sel == SEL_CTRL) begin
      rd_mux = word_q;
      rd_mux[1:0] = rd_mux[1:0] | reg_cpu;
    end else begin
      for (int i = 0; i < NCPU; i++) begin
        if (reg_sel[SEL_W-1] && (reg_sel[SEL_W-2:0] == i[SEL_W-2:0]))
          rd_mux = {{PAD_W{1'b0}}, cnt[i]};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= reg_rd;
      if (reg_rd) rd_data <= rd_mux;
    end
  end

  assign ipi_irq = word_q[IPI_LSB +: NCPU];
  assign tmr_irq = word_q[TMR_LSB +: NCPU];

  // R2: read data follows the strobe by exactly one cycle
  assert_rd_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> rd_valid);
  assert_rd_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !rd_valid);
  // R11: unused selects hold all state
  assert_dead_sel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && !reg_sel[SEL_W-1] && reg_sel != SEL_CTRL && !tick_rise)
      |=> $stable(word_q));

  initial begin
    assert_ncpu_fits: assert (NCPU >= 1 && NCPU <= MAX_CPU);
    assert_cnt_fits: assert (CNT_W >= 2 && CNT_W <= 24);
  end
endmodule

// File: tb/test_cpu_event_irq_unit.sv
module test_cpu_event_irq_unit;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        tick_in = 0;
  logic        reg_wr = 0;
  logic        reg_rd = 0;
  logic [2:0]  reg_sel = 0;
  logic [1:0]  reg_cpu = 0;
  logic [63:0] reg_wdata = 0;
  logic        rd_valid;
  logic [63:0] rd_data;
  logic [3:0]  ipi_irq;
  logic [3:0]  tmr_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_event_irq_unit i_cpu_event_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_cpu(reg_cpu), .reg_wdata(reg_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ipi_irq(ipi_irq), .tmr_irq(tmr_irq)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] cpu,
                    input logic [63:0] exp, input string req);
    @(negedge clk);
    reg_sel = s; reg_cpu = cpu; reg_rd = 1;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_in = 1;
    repeat (3) @(negedge clk);
    tick_in = 0;
    @(negedge clk);
  endtask

  // monitor: pops expected read results as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check("R2 unexpected rd_valid", 64'd1, 64'd0);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 rd_valid", {63'd0, rd_valid}, 64'd0);
    check("R1 ipi_irq", {60'd0, ipi_irq}, 64'd0);
    check("R1 tmr_irq", {60'd0, tmr_irq}, 64'd0);
    rst_n = 1;
    rd(3'd0, 2'd2, 64'h2, "R2 R1 control word with cpu index");
    rd(3'd4, 2'd0, 64'h0, "R1 counter zero");

    // R5: request bits set interprocessor flags
    wr(3'd0, 64'h5000);
    check("R5 R7 ipi after request", {60'd0, ipi_irq}, 64'h5);
    rd(3'd0, 2'd0, 64'h500, "R5 word after request");
    // R3: clear bit 10; R5: set wins over clear on bit 8
    wr(3'd0, 64'h1500);
    check("R3 R5 ipi clear and set", {60'd0, ipi_irq}, 64'h1);
    // R3: bit 28 stays zero
    wr(3'd0, 64'h1000_0000);
    rd(3'd0, 2'd0, 64'h100, "R3 bit 28 reads zero");

    // R4: arbitration fields
    wr(3'd0, 64'h00A0_0000);
    wr(3'd0, 64'h0003_0000);
    wr(3'd0, 64'h000C_0000);
    rd(3'd0, 2'd3, 64'h00A3_0103, "R4 accumulate and set-once");
    wr(3'd0, 64'h0010_0000);
    rd(3'd0, 2'd1, 64'h101, "R4 wipe");

    // R6: plain field
    wr(3'd0, 64'h0000_0A00_0000_0000);
    rd(3'd0, 2'd0, 64'h0000_0A00_0000_0100, "R6 plain field set");
    wr(3'd0, 64'h0);
    rd(3'd0, 2'd0, 64'h100, "R6 plain field replaced");
    wr(3'd0, 64'h100);
    check("R3 ipi cleared", {60'd0, ipi_irq}, 64'h0);

    // R11: dead selects
    wr(3'd1, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(3'd0, 2'd0, 64'h0, "R11 write to dead select ignored");
    rd(3'd2, 2'd0, 64'h0, "R11 dead select reads zero");
    check("R11 outputs untouched", {56'd0, ipi_irq, tmr_irq}, 64'h0);

    // R8 R9 R10: counters and ticks
    wr(3'd5, 64'h2);
    rd(3'd5, 2'd0, 64'h2, "R8 counter load");
    tick();
    check("R10 tmr after first tick", {60'd0, tmr_irq}, 64'hD);
    rd(3'd5, 2'd0, 64'h1, "R9 single decrement on held level");
    tick();
    check("R10 tmr after second tick", {60'd0, tmr_irq}, 64'hD);
    tick();
    check("R10 R7 tmr after wrap", {60'd0, tmr_irq}, 64'hF);
    rd(3'd4, 2'd0, 64'h1FF_FFFD, "R9 wrap and sticky decrement");
    rd(3'd5, 2'd0, 64'h1FF_FFFF, "R9 wrap to all ones");

    wr(3'd0, 64'hF0);
    check("R3 tmr cleared", {60'd0, tmr_irq}, 64'h0);
    wr(3'd4, 64'h5);
    wr(3'd6, 64'h5);
    wr(3'd7, 64'h5);
    tick();
    check("R10 sticky re-assert", {60'd0, tmr_irq}, 64'h2);
    rd(3'd4, 2'd0, 64'h4, "R8 R9 reloaded counter");
    rd(3'd5, 2'd0, 64'h1FF_FFFE, "R9 sticky flag kept");

    wr(3'd6, 64'hFFFF_FFFF_FF00_0003);
    rd(3'd6, 2'd0, 64'h3, "R8 upper bits dropped");

    repeat (3) @(negedge clk);
    check("R2 all reads returned", 64'(exp_q.size()), 64'd0);
    finish_run();
  end
endmodule